// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a synchronous request port to an external asynchronous static RAM of 65,536 words by 16 bits. A requester offers one word access at a time with a valid/ready handshake. Each request carries a read/write flag, a 16-bit word address, 16 bits of write data and a two-bit lane mask. The controller runs the RAM's active-low strobes through a fixed sequence of phases. When it finishes, it reports with a one-cycle done pulse and, for reads, the captured word.

The controller is a five-state machine. IDLE waits for a request and is the deselected standby state. SETUP selects the device and presents the address, lane enables and any write data, while write and output enables are still inactive. STROBE holds write enable (writes) or output enable (reads) active for a counted number of wait cycles. HOLD releases the strobe and keeps address, lanes and write data steady for one more cycle. DONE deselects the device and pulses done.

The transitions are as follows. IDLE→SETUP happens on an accepted request with a non-zero mask. IDLE→DONE happens on an accepted request with an all-zero mask. SETUP→STROBE always follows. STROBE→HOLD follows on the last wait cycle. HOLD→DONE and DONE→IDLE are unconditional. The bidirectional data bus is split into an output word, an output-enable and an input word, and the pad is left to the surrounding chip.

Top module: `sram_bridge`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both lane enables are high, the bus is not driven, `req_ready` is 1 and `rsp_done` is 0.
- R2: `req_ready` is 1 only in IDLE. A request is taken only when valid and ready are both 1, and `req_ready` stays 0 until the access has returned to IDLE.
- R3: A write with a non-zero mask runs the phases in order, each phase on the cycle after the previous one. First comes one SETUP cycle: chip enable low, write enable high, bus driven. Then write enable is low for the wait count. Then one HOLD cycle follows: write enable high, chip enable low, bus still driven with the same data and address.
- R4: The wait count of the strobe phase is the smallest number of clock cycles whose length is at least 45 ns. With the default 20 ns clock this is 3.
- R5: A read with a non-zero mask has one SETUP cycle with output enable high. It then holds output enable low and write enable high for the wait count, and ends with one HOLD cycle with output enable high. The bus is never driven during a read.
- R6: Read data is sampled at the end of the last output-enable-low cycle. In `rsp_rdata`, bit 0 of the mask governs bits 7:0 and bit 1 governs bits 15:8, and a lane whose mask bit is 0 reads as zero.
- R7: `rsp_done` is high for exactly one cycle. Chip enable is high in that cycle, and the block is back in IDLE on the next cycle.
- R8: A request with mask 00 gives `rsp_done` on the cycle after acceptance. It never pulls chip enable low, changes no memory contents and returns `rsp_rdata` of zero.
- R9: The bus is never driven while output enable is low, and write enable is low only while the bus is driven and chip enable is low.
- R10: During an access, `sram_be_n[0]` (bits 7:0) and `sram_be_n[1]` (bits 15:8) are the inverse of the matching mask bits. In IDLE and DONE both lane enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 16 | Address to the RAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Lane enables, active low: bit 0 lower, bit 1 upper |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Data received from the RAM |

## Verification
A behavioural RAM in the bench returns a filler pattern on any lane that is not actively being read. A controller that samples read data one cycle late, after output enable has risen, would therefore return filler instead of the stored word. Partial-lane writes followed by full reads expose a write that ignores its lane enable and overwrites the neighbouring byte. Masked-off read lanes must come back zero, so a missing lane gate leaks filler into `rsp_rdata`. A mask-00 write followed by a read of the same word shows whether an empty request still touched the device. Every cycle is compared against an expected strobe pattern, so a short or long wait count, a missing setup or hold cycle, a bus driven under output enable, or a done pulse without chip enable returning high all show up as a mismatch.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4
    } bridge_state_t;

    // Smallest whole number of clock periods covering the required time.
    function automatic int unsigned wait_cycles(input int unsigned t_need_ps,
                                                input int unsigned t_clk_ps);
        int unsigned n;
        n = (t_need_ps + t_clk_ps - 1) / t_clk_ps;
        if (n == 0) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer #(
    parameter int unsigned WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!run)                 cnt_q <= '0;
        else if (cnt_q != LAST_V)      cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_V);

    // Counter stays idle outside the strobe phase (R4)
    p_timer_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    // Counter never runs past its terminal value (R4)
    p_timer_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [LANES-1:0]          mask,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= '0;
            else if (clear)   lane_q <= '0;
            else if (capture) lane_q <= mask[g] ? din[g*LANE_W +: LANE_W] : '0;
        end
        assign dout[g*LANE_W +: LANE_W] = lane_q;

        // Unselected lane holds zero after a capture (R6)
        p_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && !clear && !mask[g]) |=> (lane_q == '0));
    end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned LANE_W     = 8,
    parameter int unsigned LANES      = 2,
    parameter int unsigned CLK_PS     = 20000,
    parameter int unsigned T_ACCESS_PS = 45000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_mask,
    output logic                     rsp_done,
    output logic [LANES*LANE_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]        sram_addr,
    output logic                     sram_ce_n,
    output logic                     sram_oe_n,
    output logic                     sram_we_n,
    output logic [LANES-1:0]         sram_be_n,
    output logic [LANES*LANE_W-1:0]  sram_dq_out,
    output logic                     sram_dq_oe,
    input  logic [LANES*LANE_W-1:0]  sram_dq_in
);
    localparam int unsigned DATA_W   = LANES * LANE_W;
    localparam int unsigned WAIT_CYC = wait_cycles(T_ACCESS_PS, CLK_PS);

    bridge_state_t       state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    mask_q;
    logic                write_q;
    logic                accept;
    logic                strobe_last;
    logic                capture;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            write_q <= req_write;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (req_mask == '0) ? ST_DONE : ST_SETUP;
            end
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (strobe_last) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_done   = 1'b0;
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_be_n  = '1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP: begin
                sram_ce_n  = 1'b0;
                sram_be_n  = ~mask_q;
                sram_dq_oe = write_q;
            end
            ST_STROBE: begin
                sram_ce_n  = 1'b0;
                sram_be_n  = ~mask_q;
                sram_we_n  = ~write_q;
                sram_oe_n  = write_q;
                sram_dq_oe = write_q;
            end
            ST_HOLD: begin
                sram_ce_n  = 1'b0;
                sram_be_n  = ~mask_q;
                sram_dq_oe = write_q;
            end
            ST_DONE: rsp_done = 1'b1;
            default: ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    sram_strobe_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_STROBE),
        .last  (strobe_last)
    );

    assign capture = strobe_last && !write_q;

    sram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture),
        .mask    (mask_q),
        .din     (sram_dq_in),
        .dout    (rsp_rdata)
    );

    // Never drive the bus while the RAM may drive it (R9)
    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);
    // Write strobe only with data on the bus and the device selected (R9)
    p_we_with_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && !sram_ce_n));
    // Write strobe falls only after a cycle of set-up (R3)
    p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && !$past(sram_ce_n) && $stable(sram_addr)));
    // Data and address held one cycle after write strobe rises (R3)
    p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_dq_out) && $stable(sram_addr)));
    // Done is a single-cycle pulse with the device deselected (R7)
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (sram_ce_n && &sram_be_n) ##1 (!rsp_done && req_ready));
    // Ready only while idle, never together with done (R2)
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !rsp_done));
    // Chip enable never pulled low for an empty mask (R8)
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> (rsp_done && sram_ce_n));
endmodule

// File: tb/sram_bridge_bench.sv
`timescale 1ns/1ps
module sram_bridge_bench;
    localparam int WAITS = 3;            // ceil(45 ns / 20 ns)
    localparam logic [15:0] FILL = 16'h5AC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in = FILL;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [15:0] ram [int];
    logic [15:0] refm [int];

    always #10 clk = ~clk;

    sram_bridge u_sram_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic logic [15:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] ref_rd(input int a);
        return refm.exists(a) ? refm[a] : 16'h0000;
    endfunction

    // Behavioural asynchronous RAM: lane writes while CE and WE are low
    always @(posedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n) begin
            logic [15:0] w;
            w = ram_rd(int'(sram_addr));
            if (!sram_be_n[0]) w[7:0]  = sram_dq_out[7:0];
            if (!sram_be_n[1]) w[15:8] = sram_dq_out[15:8];
            ram[int'(sram_addr)] = w;
        end
    end

    // Read path: a lane returns data only when selected and output-enabled
    always @(negedge clk) begin
        logic [15:0] r;
        r = FILL;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            if (!sram_be_n[0]) r[7:0]  = ram_rd(int'(sram_addr))[7:0];
            if (!sram_be_n[1]) r[15:8] = ram_rd(int'(sram_addr))[15:8];
        end
        sram_dq_in = r;
    end

    // Contention monitor on every cycle (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if ((sram_dq_oe && !sram_oe_n) || (!sram_we_n && (!sram_dq_oe || sram_ce_n))) begin
                bad++;
                $display("FAIL R9 bus rule: dq_oe=%b oe_n=%b we_n=%b ce_n=%b expected no drive under oe_n low",
                         sram_dq_oe, sram_oe_n, sram_we_n, sram_ce_n);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {ce_n, oe_n, we_n, be_n[1:0], dq_oe, ready, done}
    function automatic logic [31:0] pins();
        return {24'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe, req_ready, rsp_done};
    endfunction
    function automatic logic [31:0] pat(input logic ce, oe, we, input logic [1:0] be,
                                        input logic oe_d, rdy, dn);
        return {24'd0, ce, oe, we, be, oe_d, rdy, dn};
    endfunction

    task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        logic [15:0] exp_rd;
        logic [15:0] lane_m;
        lane_m = {{8{m[1]}}, {8{m[0]}}};
        @(negedge clk);
        check("R2 idle ready", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            check("R8 empty mask done at once", pins(), pat(1, 1, 1, 2'b11, 0, 0, 1));
            check("R8 empty mask rdata", {16'd0, rsp_rdata}, 32'd0);
        end else begin
            check("R3/R5 setup cycle", pins(), pat(0, 1, 1, ~m, wr, 0, 0));
            if (wr) check("R3 setup data", {sram_addr, sram_dq_out}, {a, d});
            for (int k = 0; k < WAITS; k++) begin
                @(negedge clk);
                check(wr ? "R4 write strobe cycle" : "R4 read strobe cycle", pins(),
                      pat(0, wr, !wr, ~m, wr, 0, 0));
            end
            @(negedge clk);
            check("R3/R5 hold cycle", pins(), pat(0, 1, 1, ~m, wr, 0, 0));
            if (wr) check("R3 hold data", {sram_addr, sram_dq_out}, {a, d});
            @(negedge clk);
            check("R7/R10 done cycle", pins(), pat(1, 1, 1, 2'b11, 0, 0, 1));
            if (wr) refm[int'(a)] = (ref_rd(int'(a)) & ~lane_m) | (d & lane_m);
            else begin
                exp_rd = ref_rd(int'(a)) & lane_m;
                check("R6 read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
            end
        end
        @(negedge clk);
        check("R7 back to idle", pins(), pat(1, 1, 1, 2'b11, 0, 1, 0));
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 reset state", pins(), pat(1, 1, 1, 2'b11, 0, 1, 0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pins(), pat(1, 1, 1, 2'b11, 0, 1, 0));

        access(1, 16'h1234, 16'hBEEF, 2'b11);
        access(0, 16'h1234, 16'h0000, 2'b11);
        access(1, 16'h1234, 16'h00C4, 2'b01);   // lower lane only (R10)
        access(0, 16'h1234, 16'h0000, 2'b11);   // expect BEC4
        access(1, 16'h1234, 16'h7700, 2'b10);   // upper lane only
        access(0, 16'h1234, 16'h0000, 2'b01);   // upper must read zero (R6)
        access(0, 16'h1234, 16'h0000, 2'b10);   // lower must read zero (R6)
        access(1, 16'h1234, 16'hFFFF, 2'b00);   // no effect (R8)
        access(0, 16'h1234, 16'h0000, 2'b11);   // still 77C4
        access(0, 16'h1234, 16'h0000, 2'b00);   // empty read gives zero
        access(1, 16'h0000, 16'hA001, 2'b11);
        access(1, 16'hFFFF, 16'h0FF1, 2'b11);
        access(0, 16'h0000, 16'h0000, 2'b11);
        access(0, 16'hFFFF, 16'h0000, 2'b11);

        lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(1, {12'h3A0, lfsr[3:0]}, lfsr ^ 16'h1F2E, lfsr[5:4]);
            access(0, {12'h3A0, lfsr[7:4]}, 16'h0000, lfsr[9:8]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule